// File: doc/BRIEF.md
# Expansion Window Chip-Select Decoder

This block turns a 28-bit offset inside a 256-MByte expansion window into one of eight active-low chip selects. Every select has a 5-bit size code. The codes together choose one of two window layouts. If any select carries the 32-MByte code, the eight windows are 32 MBytes apart and fill the whole region. If none does, they are 16 MBytes apart, and the upper half of the region belongs to no select.

A request strobe and an address come in together. One clock later the block presents three registered results: the chip-select vector, the offset masked to the selected device's size, and an error flag. The flag rises only in the 16-MByte layout. It marks an access that hits no window, or one that lands past the programmed size of the addressed device. In the 32-MByte layout, an access past a small device's size but still inside its window wraps silently and raises no error. This keeps the address map fixed when one select is set to 32 MBytes only to reserve room.

Top module: `exp_cs_decoder`

## Requirements
- R1: While reset is asserted and right after it, all chip selects are high, the error flag is low and the local offset is zero.
- R2: A cycle with the request strobe low is followed by all chip selects high, the error flag low and the local offset zero.
- R3: The outputs for a request appear on the first rising clock edge after the strobe is sampled high. This is one register stage.
- R4: Size code field n sits at bits [5n+4:5n] of the configuration bus. Code 0b00001 means 32 MBytes. Any other code c means 2^(9 + c[4:1]) bytes, with bit 0 ignored. So 0b00000 is 512 bytes, 0b10110 is 1 MByte and 0b11110 is 16 MBytes.
- R5: If any field holds 0b00001, select n owns offsets n*0x2000000 to n*0x2000000+0x1FFFFFF. The index is address bits [27:25].
- R6: In the 32-MByte layout the error flag never rises, even past the addressed device's size. The select for the window is still asserted.
- R7: If no field holds 0b00001, select n owns offsets n*0x1000000 upward. The index is address bits [26:24].
- R8: In the 16-MByte layout, an address with bit 27 set raises the error flag and leaves all chip selects high.
- R9: In the 16-MByte layout, an address whose bits [23:0] are at or above the addressed device's size raise the error flag and leave all chip selects high.
- R10: The local offset is the address ANDed with (size − 1) of the addressed select. It is zero whenever the error flag is high.
- R11: At most one chip select is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 28 | Offset inside the expansion region |
| cs_cfg | input | 40 | Eight 5-bit size codes, field n at [5n+4:5n] |
| cs_n | output | 8 | Registered active-low chip selects |
| local_off | output | 28 | Registered offset masked to device size |
| win_err | output | 1 | Registered out-of-window flag |

## Verification
Random configurations are mixed so that some hold the 32-MByte code and some do not. This tells apart a decoder that picks the stride from the codes from one that fixes it. Addresses are drawn both across the full region and biased toward small in-window offsets. Full-region draws reach the dead upper half and past-size hits. Biased draws reach the legal hits whose masked offsets must match exactly.

Directed cases cover the following:
- the 512-byte and odd-code sizes, where the edge offset and the one just after it separate correct size decoding from an off-by-one;
- a 1-MByte device inside a 32-MByte window, which separates silent wrap from error reporting;
- idle cycles between requests, which show that no select stays asserted.

// File: rtl/exp_cs_pkg.sv
package exp_cs_pkg;
    localparam int CS_COUNT   = 8;
    localparam int REGION_W   = 28;
    localparam int CODE_W     = 5;
    localparam int LOG_W      = 5;
    localparam int MIN_LOG2   = 9;
    localparam logic [CODE_W-1:0] CODE_WIDE = 5'b00001;
endpackage

// File: rtl/exp_cs_size_dec.sv
module exp_cs_size_dec
    import exp_cs_pkg::*;
#(
    parameter int CFG_W  = CODE_W,
    parameter int LG_W   = LOG_W,
    parameter int WIDE_LG = 25
) (
    input  logic [CFG_W-1:0] code,
    output logic             is_wide,
    output logic [LG_W-1:0]  size_lg
);
    always_comb begin
        is_wide = (code == CODE_WIDE);
        if (is_wide) begin
            size_lg = LG_W'(WIDE_LG);
        end else begin
            size_lg = LG_W'(MIN_LOG2) + LG_W'(code[CFG_W-1:1]);
        end
    end
endmodule

// File: rtl/exp_cs_win_sel.sv
module exp_cs_win_sel #(
    parameter int ADDR_W = 28,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic [IDX_W-1:0]  idx,
    output logic              no_window
);
    always_comb begin
        if (wide) begin
            idx       = addr[ADDR_W-1 -: IDX_W];
            no_window = 1'b0;
        end else begin
            idx       = addr[ADDR_W-2 -: IDX_W];
            no_window = addr[ADDR_W-1];
        end
    end
endmodule

// File: rtl/exp_cs_decoder.sv
module exp_cs_decoder
    import exp_cs_pkg::*;
#(
    parameter int NUM_CS = CS_COUNT,
    parameter int ADDR_W = REGION_W,
    parameter int CFG_W  = CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [NUM_CS*CFG_W-1:0]  cs_cfg,
    output logic [NUM_CS-1:0]        cs_n,
    output logic [ADDR_W-1:0]        local_off,
    output logic                     win_err
);
    localparam int IDX_W     = $clog2(NUM_CS);
    localparam int WIDE_LG   = ADDR_W - IDX_W;
    localparam int NARROW_LG = WIDE_LG - 1;

    typedef struct packed {
        logic [NUM_CS-1:0] sel_n;
        logic [ADDR_W-1:0] off;
        logic              err;
    } dec_state_t;

    logic [NUM_CS-1:0] wide_vec;
    logic [LOG_W-1:0]  lg_vec [NUM_CS];

    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_size
            exp_cs_size_dec #(
                .CFG_W  (CFG_W),
                .LG_W   (LOG_W),
                .WIDE_LG(WIDE_LG)
            ) u_size (
                .code   (cs_cfg[g*CFG_W +: CFG_W]),
                .is_wide(wide_vec[g]),
                .size_lg(lg_vec[g])
            );
        end
    endgenerate

    logic             wide_map;
    logic [IDX_W-1:0] win_idx;
    logic             no_window;

    assign wide_map = |wide_vec;

    exp_cs_win_sel #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_win (
        .addr     (req_addr),
        .wide     (wide_map),
        .idx      (win_idx),
        .no_window(no_window)
    );

    dec_state_t        st_d, st_q;
    logic [LOG_W-1:0]  sel_lg;
    logic [ADDR_W-1:0] size_mask;
    logic              past_size;

    always_comb begin
        sel_lg = lg_vec[win_idx];
        for (int b = 0; b < ADDR_W; b++) begin
            size_mask[b] = (LOG_W'(b) < sel_lg);
        end
        past_size = ~wide_map &&
                    ((req_addr[NARROW_LG-1:0] & ~size_mask[NARROW_LG-1:0]) != '0);

        st_d.sel_n = '1;
        st_d.off   = '0;
        st_d.err   = 1'b0;
        if (req_valid) begin
            if (no_window || past_size) begin
                st_d.err = 1'b1;
            end else begin
                st_d.sel_n[win_idx] = 1'b0;
                st_d.off            = req_addr & size_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_n <= '1;
            st_q.off   <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n      = st_q.sel_n;
    assign local_off = st_q.off;
    assign win_err   = st_q.err;
endmodule

// File: rtl/exp_cs_decoder_chk.sv
module exp_cs_decoder_chk #(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 28,
    parameter int CFG_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [NUM_CS*CFG_W-1:0] cs_cfg,
    input  logic [NUM_CS-1:0]       cs_n,
    input  logic [ADDR_W-1:0]       local_off,
    input  logic                    win_err
);
    localparam int IDX_W = $clog2(NUM_CS);

    logic has_wide;
    always_comb begin
        has_wide = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cs_cfg[i*CFG_W +: CFG_W] == CFG_W'(1)) has_wide = 1'b1;
        end
    end

    assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (&cs_n && !win_err && local_off == '0));

    assert_err_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |-> (&cs_n && local_off == '0));

    assert_wide_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && has_wide) |=> !win_err);

    assert_wide_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && has_wide) |=> !cs_n[$past(req_addr[ADDR_W-1 -: IDX_W])]);

    assert_upper_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !has_wide && req_addr[ADDR_W-1]) |=> (win_err && &cs_n));
endmodule

bind exp_cs_decoder exp_cs_decoder_chk #(
    .NUM_CS(NUM_CS),
    .ADDR_W(ADDR_W),
    .CFG_W (CFG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .cs_cfg   (cs_cfg),
    .cs_n     (cs_n),
    .local_off(local_off),
    .win_err  (win_err)
);

// File: tb/sim_exp_cs_decoder.sv
`timescale 1ns/1ps
module sim_exp_cs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [27:0] req_addr = '0;
    logic [39:0] cs_cfg;
    logic [7:0]  cs_n;
    logic [27:0] local_off;
    logic        win_err;
    logic [4:0]  cfg_b [8];

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) cs_cfg[i*5 +: 5] = cfg_b[i];
    end

    exp_cs_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cs_cfg(cs_cfg), .cs_n(cs_n), .local_off(local_off), .win_err(win_err)
    );

    function automatic int size_lg(input logic [4:0] c);
        if (c == 5'b00001) return 25;
        return 9 + int'(c[4:1]);
    endfunction

    function automatic bit any_wide();
        for (int i = 0; i < 8; i++) if (cfg_b[i] == 5'b00001) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model(input logic v, input logic [27:0] a,
                                  output logic [7:0] ecs, output logic [27:0] eoff,
                                  output logic eerr, output string tag);
        bit w;
        int idx;
        longint sz;
        w = any_wide();
        ecs = 8'hFF; eoff = '0; eerr = 1'b0;
        if (!v) begin tag = "R2"; return; end
        idx = w ? int'(a[27:25]) : int'(a[26:24]);
        sz  = longint'(1) << size_lg(cfg_b[idx]);
        if (!w && a[27]) begin eerr = 1'b1; tag = "R8"; return; end
        if (!w && longint'(a[23:0]) >= sz) begin eerr = 1'b1; tag = "R9"; return; end
        ecs = ~(8'b1 << idx);
        eoff = a & 28'(sz - 1);
        if (w) tag = (longint'(a[24:0]) >= sz) ? "R6" : "R5";
        else   tag = "R7";
    endfunction

    task automatic check(input string tag, input logic [7:0] ecs,
                         input logic [27:0] eoff, input logic eerr);
        n_vec++;
        if (cs_n !== ecs || local_off !== eoff || win_err !== eerr) begin
            n_bad++;
            $display("FAIL %s: cs_n=%h off=%h err=%b expected cs_n=%h off=%h err=%b",
                     tag, cs_n, local_off, win_err, ecs, eoff, eerr);
        end
        n_vec++;
        if ($countones(~cs_n) > 1) begin
            n_bad++;
            $display("FAIL R11: cs_n=%h expected at most one low", cs_n);
        end
    endtask

    task automatic apply(input logic v, input logic [27:0] a, input string force_tag);
        logic [7:0] ecs; logic [27:0] eoff; logic eerr; string tag;
        @(negedge clk);
        req_valid = v; req_addr = a;
        model(v, a, ecs, eoff, eerr, tag);
        if (force_tag != "") tag = {force_tag, "/", tag};
        @(negedge clk);
        check(tag, ecs, eoff, eerr);
    endtask

    function automatic logic [4:0] pick_code(input int r);
        case (r % 8)
            0: return 5'b11110;
            1: return 5'b11100;
            2: return 5'b11010;
            3: return 5'b11000;
            4: return 5'b10110;
            5: return 5'b00000;
            6: return 5'b01101;
            default: return 5'b11111;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired before completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C5D));
        for (int i = 0; i < 8; i++) cfg_b[i] = 5'b11110;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", 8'hFF, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'hFF, '0, 1'b0);

        // R3: single request then idle
        apply(1'b1, 28'h3000010, "R3");
        apply(1'b0, 28'h3000010, "R2");

        // R4: 512-byte and odd-code devices in narrow layout
        cfg_b[2] = 5'b00000;
        apply(1'b1, 28'h20001FF, "R4");
        apply(1'b1, 28'h2000200, "R4");
        cfg_b[5] = 5'b00011;
        apply(1'b1, 28'h50003FF, "R4");
        apply(1'b1, 28'h5000400, "R4");
        apply(1'b1, 28'hF000000, "R8");
        apply(1'b1, 28'h7FFFFFF, "R7");

        // R5 R6 R10: 1-MByte device in a 32-MByte window
        cfg_b[0] = 5'b00001;
        cfg_b[3] = 5'b10110;
        apply(1'b1, 28'h7234567, "R10");
        apply(1'b1, 28'h60FFFFF, "R5");
        apply(1'b1, 28'hFFFFFFF, "R6");
        apply(1'b0, 28'h0, "R2");

        for (int k = 0; k < 3000; k++) begin
            logic [27:0] a;
            if (k % 50 == 0) begin
                bit mk;
                mk = ($urandom % 3) == 0;
                for (int i = 0; i < 8; i++) cfg_b[i] = pick_code($urandom);
                if (mk) cfg_b[$urandom % 8] = 5'b00001;
            end
            a = 28'($urandom);
            if (($urandom % 2) == 0) a = {1'b0, a[26:24], 4'h0, a[23:0] & 24'h0003FF};
            apply(($urandom % 8) != 0, a, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule